// File: doc/BRIEF.md
# Polled Eight-Input Interrupt Controller

This block collects eight level-sensitive interrupt requests, masks them, ranks them by a fixed priority and tracks which ones software is currently servicing. Software reaches it through a two-address byte port: address 0 carries command bytes and returns status, and address 1 carries the mask and the configuration bytes. The interrupt is acknowledged by a register poll and not by a bus acknowledge cycle. Software arms a poll with a command, and the next status read returns the winning input number and marks it as in service.

A configuration sequence is started by a command byte and followed by three bytes on address 1: a vector base, a chaining byte and a mode byte. Two instances can be chained. A slave's interrupt output drives the master's chain input, and the master merges it into every input named in its chaining byte. A slave keeps its chaining byte as an identity number. If a request drops between arming a poll and reading it, the read reports input 7 without setting that input's in-service bit, so software can treat it as spurious.

Top module: `pic8_poll`

## Requirements
- R1: After reset the mask is 0xFF, the in-service and request registers are zero, address-0 reads return the request register and `int_out` is low.
- R2: A write to address 0 with bit 4 set (for example 0x11) clears the in-service register and the mask, selects the request register for status reads, cancels an armed poll and starts configuration. The next three writes to address 1 are taken as the vector base, the chaining byte and the mode byte, and none of them loads the mask.
- R3: From the configuration start until the third configuration byte is written, `int_out` stays low and no poll grants an input.
- R4: Outside configuration, a write to address 1 loads the mask, where a 1 disables the input. A read of address 1 returns the mask.
- R5: Priority is fixed with input 0 highest. `int_out` is high when an unmasked request outranks every input in service. `vec_o` is vector base bits 7..3 joined with the number of the winning input.
- R6: Command 0x0C arms a poll. The next read of address 0 returns bit 7 = 1 and the winning input number in bits 2..0. It sets that input's in-service bit, and it disarms the poll, so later reads return the selected register again.
- R7: If no input qualifies at the poll read, the read returns 0x07 and the in-service register is left unchanged, with bit 7 staying clear.
- R8: Command 0x60+n clears in-service bit n and leaves the other bits as they are. Command 0x20 clears the highest-priority set in-service bit.
- R9: Command 0x0A selects the request register and 0x0B selects the in-service register for address-0 reads. The request register follows the inputs one clock later.
- R10: In the master variant, `chain_in` drives every input whose chaining-byte bit is set. The slave variant ignores `chain_in` and shows chaining-byte bits 2..0 on `slave_id`. The master shows zero on `slave_id`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe; read side effects happen at the clock edge |
| addr | input | 1 | 0 = command/status, 1 = mask/configuration |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while `rd_en` is high |
| irq_in | input | 8 | Level-sensitive request inputs |
| chain_in | input | 1 | Interrupt from a chained slave (master variant) |
| int_out | output | 1 | Qualified request present |
| vec_o | output | 8 | Vector of the winning input |
| slave_id | output | 3 | Identity number (slave variant), zero on a master |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that a byte written to address 0 with bits 7..3 equal to 01100 is meant as a specific end-of-interrupt. The bench respects both assumptions: every bus access runs in a task that raises exactly one strobe for one cycle and then drops it. Request inputs change only on the falling clock edge. The bench waits one cycle for a master input, or two cycles for a path through the chained slave, before it samples `int_out` or a status read.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        ST_READY,
        ST_BASE,
        ST_CASC,
        ST_MODE
    } init_st_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_INIT,
        CMD_POLL,
        CMD_SEL_IRR,
        CMD_SEL_ISR,
        CMD_EOI_SPEC,
        CMD_EOI_NSPEC
    } cmd_e;

    // bit positions of the command byte at address 0
    localparam int CMD_INIT_BIT = 4;
    localparam int CMD_OCW3_BIT = 3;
    localparam int CMD_POLL_BIT = 2;
    localparam int CMD_RSEL_BIT = 1;
    localparam logic [2:0] EOI_SPEC_CODE  = 3'b011;
    localparam logic [2:0] EOI_NSPEC_CODE = 3'b001;

endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N = 8
) (
    input  logic [N-1:0]         vec,
    output logic                 hit,
    output logic [$clog2(N)-1:0] idx,
    output logic [N-1:0]         onehot
);
    localparam int IW = $clog2(N);

    // lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign hit    = |vec;
    assign onehot = vec & (~vec + 1'b1);
endmodule

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
    import pic_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  cmd_byte,
    output cmd_e          kind,
    output logic [IW-1:0] lvl
);
    always_comb begin
        lvl  = cmd_byte[IW-1:0];
        kind = CMD_NONE;
        if (cmd_byte[CMD_INIT_BIT]) begin
            kind = CMD_INIT;
        end else if (cmd_byte[CMD_OCW3_BIT]) begin
            if (cmd_byte[CMD_POLL_BIT])
                kind = CMD_POLL;
            else if (cmd_byte[CMD_RSEL_BIT])
                kind = cmd_byte[0] ? CMD_SEL_ISR : CMD_SEL_IRR;
        end else begin
            case (cmd_byte[W-1:W-3])
                EOI_SPEC_CODE:  kind = CMD_EOI_SPEC;
                EOI_NSPEC_CODE: kind = CMD_EOI_NSPEC;
                default:        kind = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pic8_poll.sv
module pic8_poll
    import pic_pkg::*;
#(
    parameter int N_IN     = 8,
    parameter bit IS_SLAVE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     addr,
    input  logic [N_IN-1:0]          wdata,
    output logic [N_IN-1:0]          rdata,
    input  logic [N_IN-1:0]          irq_in,
    input  logic                     chain_in,
    output logic                     int_out,
    output logic [N_IN-1:0]          vec_o,
    output logic [$clog2(N_IN)-1:0]  slave_id
);
    localparam int IDX_W  = $clog2(N_IN);
    localparam int BASE_W = N_IN - IDX_W;
    localparam int PAD_W  = N_IN - 1 - IDX_W;

    typedef struct packed {
        init_st_e          st;
        logic [N_IN-1:0]   imr;
        logic [N_IN-1:0]   isr;
        logic [N_IN-1:0]   irr;
        logic [N_IN-1:0]   casc;
        logic [BASE_W-1:0] base_hi;
        logic              sel_isr;
        logic              poll_armed;
    } pic_state_t;

    pic_state_t st_d, st_q;

    logic [N_IN-1:0]  isr_q, irr_q, imr_q, casc_q;
    logic             poll_armed_q, ready;
    logic [N_IN-1:0]  req_eff;

    assign isr_q        = st_q.isr;
    assign irr_q        = st_q.irr;
    assign imr_q        = st_q.imr;
    assign casc_q       = st_q.casc;
    assign poll_armed_q = st_q.poll_armed;
    assign ready        = (st_q.st == ST_READY);

    // chaining variant
    generate
        if (IS_SLAVE) begin : g_slave
            assign req_eff  = irq_in;
            assign slave_id = casc_q[IDX_W-1:0];
        end else begin : g_master
            assign req_eff  = irq_in | (casc_q & {N_IN{chain_in}});
            assign slave_id = '0;
        end
    endgenerate

    // in-service ceiling
    logic             isr_hit;
    logic [IDX_W-1:0] isr_idx;
    logic [N_IN-1:0]  isr_oh;
    pic_prio_enc #(.N(N_IN)) u_isr_enc (
        .vec(isr_q), .hit(isr_hit), .idx(isr_idx), .onehot(isr_oh)
    );

    logic [N_IN-1:0] allowed, qual;
    assign allowed = isr_hit ? (isr_oh - 1'b1) : '1;
    assign qual    = irr_q & ~imr_q & allowed & {N_IN{ready}};

    logic             q_hit;
    logic [IDX_W-1:0] q_idx;
    logic [N_IN-1:0]  q_oh;
    pic_prio_enc #(.N(N_IN)) u_req_enc (
        .vec(qual), .hit(q_hit), .idx(q_idx), .onehot(q_oh)
    );

    cmd_e             cmd_kind;
    logic [IDX_W-1:0] cmd_lvl;
    pic_cmd_dec #(.W(N_IN), .IW(IDX_W)) u_dec (
        .cmd_byte(wdata), .kind(cmd_kind), .lvl(cmd_lvl)
    );

    logic [N_IN-1:0] poll_byte;
    assign poll_byte = q_hit ? {1'b1, {PAD_W{1'b0}}, q_idx}
                             : {1'b0, {PAD_W{1'b0}}, {IDX_W{1'b1}}};

    always_comb begin
        if (addr)                rdata = imr_q;
        else if (poll_armed_q)   rdata = poll_byte;
        else if (st_q.sel_isr)   rdata = isr_q;
        else                     rdata = irr_q;
    end

    assign int_out = q_hit;
    assign vec_o   = {st_q.base_hi, q_idx};

    always_comb begin
        st_d     = st_q;
        st_d.irr = req_eff;

        if (rd_en && !addr && poll_armed_q) begin
            st_d.poll_armed = 1'b0;
            if (q_hit) begin
                st_d.isr = isr_q | q_oh;
                st_d.irr = req_eff & ~q_oh;
            end
        end

        if (wr_en) begin
            if (!addr) begin
                case (cmd_kind)
                    CMD_INIT: begin
                        st_d.isr        = '0;
                        st_d.imr        = '0;
                        st_d.sel_isr    = 1'b0;
                        st_d.poll_armed = 1'b0;
                        st_d.st         = ST_BASE;
                    end
                    CMD_POLL:      st_d.poll_armed = 1'b1;
                    CMD_SEL_IRR:   st_d.sel_isr    = 1'b0;
                    CMD_SEL_ISR:   st_d.sel_isr    = 1'b1;
                    CMD_EOI_SPEC:  st_d.isr[cmd_lvl] = 1'b0;
                    CMD_EOI_NSPEC: st_d.isr[isr_idx] = 1'b0;
                    default: ;
                endcase
            end else begin
                case (st_q.st)
                    ST_BASE: begin
                        st_d.base_hi = wdata[N_IN-1:IDX_W];
                        st_d.st      = ST_CASC;
                    end
                    ST_CASC: begin
                        st_d.casc = wdata;
                        st_d.st   = ST_MODE;
                    end
                    ST_MODE: st_d.st  = ST_READY;
                    default: st_d.imr = wdata;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.st         <= ST_READY;
            st_q.imr        <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pic8_poll_chk.sv
module pic8_poll_chk #(
    parameter int N_IN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            addr,
    input logic [N_IN-1:0] wdata,
    input logic            int_out,
    input logic [N_IN-1:0] isr_q,
    input logic [N_IN-1:0] irr_q,
    input logic [N_IN-1:0] imr_q,
    input logic            poll_armed_q,
    input logic            ready
);
    localparam int IDX_W = $clog2(N_IN);

    p_isr_needs_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(isr_q & ~$past(isr_q))) |-> $past(rd_en && !addr && poll_armed_q));

    p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_q & ~$past(isr_q)) <= 1);

    p_poll_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !addr && poll_armed_q) |=> !poll_armed_q);

    p_spec_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !addr && wdata[7:3] == 5'b01100)
            |=> !isr_q[$past(wdata[IDX_W-1:0])]);

    p_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(irr_q & ~imr_q)));

    p_ready_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ready);

    p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (isr_q == '0 && imr_q == '0 && !poll_armed_q));
endmodule

bind pic8_poll pic8_poll_chk #(.N_IN(N_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .int_out(int_out), .isr_q(isr_q), .irr_q(irr_q),
    .imr_q(imr_q), .poll_armed_q(poll_armed_q), .ready(ready)
);

// File: tb/test_pic8_poll.sv
module test_pic8_poll;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       m_wr = 0, m_rd = 0, m_addr = 0;
    logic [7:0] m_wd = 0, m_rdata, m_irq = 0, m_vec;
    logic       m_int;
    logic [2:0] m_id;

    logic       s_wr = 0, s_rd = 0, s_addr = 0;
    logic [7:0] s_wd = 0, s_rdata, s_irq = 0, s_vec;
    logic       s_int;
    logic [2:0] s_id;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    pic8_poll #(.N_IN(8), .IS_SLAVE(1'b0)) i_pic8_poll (
        .clk(clk), .rst_n(rst_n), .wr_en(m_wr), .rd_en(m_rd), .addr(m_addr),
        .wdata(m_wd), .rdata(m_rdata), .irq_in(m_irq), .chain_in(s_int),
        .int_out(m_int), .vec_o(m_vec), .slave_id(m_id)
    );

    // slave's chain input tied high: it must be ignored
    pic8_poll #(.N_IN(8), .IS_SLAVE(1'b1)) i_pic8_poll_slave (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .rd_en(s_rd), .addr(s_addr),
        .wdata(s_wd), .rdata(s_rdata), .irq_in(s_irq), .chain_in(1'b1),
        .int_out(s_int), .vec_o(s_vec), .slave_id(s_id)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input bit slv, input bit a, input logic [7:0] d);
        @(negedge clk);
        if (slv) begin s_wr = 1; s_addr = a; s_wd = d; end
        else     begin m_wr = 1; m_addr = a; m_wd = d; end
        @(negedge clk);
        m_wr = 0; s_wr = 0;
    endtask

    task automatic bus_rd(input bit slv, input bit a, output logic [7:0] d);
        @(negedge clk);
        if (slv) begin s_rd = 1; s_addr = a; end
        else     begin m_rd = 1; m_addr = a; end
        #1;
        d = slv ? s_rdata : m_rdata;
        @(negedge clk);
        m_rd = 0; s_rd = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_rd(0, 1, v); check("R1 mask after reset", v, 8'hFF);
        bus_rd(0, 0, v); check("R1 request status after reset", v, 8'h00);
        check("R1 int_out after reset", {7'b0, m_int}, 8'h00);
    endtask

    task automatic t_init();
        logic [7:0] v;
        m_irq = 8'h08;
        bus_wr(0, 0, 8'h11);
        wait_cyc(1);
        check("R3 int_out held during config", {7'b0, m_int}, 8'h00);
        bus_wr(0, 1, 8'h40);
        bus_wr(0, 1, 8'h04);
        check("R3 int_out held before mode byte", {7'b0, m_int}, 8'h00);
        bus_wr(0, 1, 8'h01);
        check("R3 int_out after mode byte", {7'b0, m_int}, 8'h01);
        check("R5 vector of input 3", m_vec, 8'h43);
        bus_rd(0, 1, v); check("R2 mask cleared, config bytes not loaded", v, 8'h00);
        bus_wr(1, 0, 8'h11);
        bus_wr(1, 1, 8'h48);
        bus_wr(1, 1, 8'h02);
        bus_wr(1, 1, 8'h01);
        wait_cyc(1);
        check("R10 slave identity", {5'b0, s_id}, 8'h02);
        check("R10 master identity zero", {5'b0, m_id}, 8'h00);
        check("R10 slave ignores chain_in", {7'b0, s_int}, 8'h00);
        bus_rd(1, 0, v); check("R10 slave request register", v, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        bus_wr(0, 1, 8'h08);
        check("R4 masked input blocked", {7'b0, m_int}, 8'h00);
        bus_rd(0, 1, v); check("R4 mask readback", v, 8'h08);
        bus_wr(0, 1, 8'h00);
        check("R4 unmasked input passes", {7'b0, m_int}, 8'h01);
    endtask

    task automatic t_irr();
        logic [7:0] v;
        m_irq = 8'h28;
        bus_wr(0, 0, 8'h0A);
        bus_rd(0, 0, v); check("R9 request register read", v, 8'h28);
    endtask

    task automatic t_poll();
        logic [7:0] v;
        bus_wr(0, 0, 8'h0C);
        bus_rd(0, 0, v); check("R6 poll result input 3", v, 8'h83);
        bus_wr(0, 0, 8'h0B);
        bus_rd(0, 0, v); check("R9 in-service after poll", v, 8'h08);
        check("R5 lower input blocked by in-service", {7'b0, m_int}, 8'h00);
        bus_rd(0, 0, v); check("R6 poll disarmed after one read", v, 8'h08);
        bus_wr(0, 0, 8'h0C);
        bus_rd(0, 0, v); check("R7 nothing qualifies", v, 8'h07);
        bus_rd(0, 0, v); check("R7 in-service unchanged", v, 8'h08);
    endtask

    task automatic t_preempt();
        logic [7:0] v;
        m_irq = 8'h2A;
        wait_cyc(1);
        check("R5 higher input preempts", {7'b0, m_int}, 8'h01);
        check("R5 vector of input 1", m_vec, 8'h41);
        bus_wr(0, 0, 8'h0C);
        bus_rd(0, 0, v); check("R6 poll result input 1", v, 8'h81);
        bus_rd(0, 0, v); check("R6 nested in-service", v, 8'h0A);
    endtask

    task automatic t_eoi();
        logic [7:0] v;
        bus_wr(0, 0, 8'h65);
        bus_rd(0, 0, v); check("R8 EOI of idle bit has no effect", v, 8'h0A);
        bus_wr(0, 0, 8'h63);
        bus_rd(0, 0, v); check("R8 specific EOI input 3", v, 8'h02);
        bus_wr(0, 0, 8'h20);
        bus_rd(0, 0, v); check("R8 non-specific EOI", v, 8'h00);
        m_irq = 8'h00;
        wait_cyc(1);
        check("R5 no request, int_out low", {7'b0, m_int}, 8'h00);
    endtask

    task automatic t_spurious();
        logic [7:0] v;
        m_irq = 8'h10;
        wait_cyc(1);
        check("R5 input 4 raises int_out", {7'b0, m_int}, 8'h01);
        bus_wr(0, 0, 8'h0C);
        m_irq = 8'h00;
        wait_cyc(1);
        bus_rd(0, 0, v); check("R7 vanished request reports 7", v, 8'h07);
        bus_rd(0, 0, v); check("R7 in-service bit 7 clear", v, 8'h00);
    endtask

    task automatic t_cascade();
        logic [7:0] v;
        s_irq = 8'h20;
        wait_cyc(2);
        check("R10 chained request reaches master", {7'b0, m_int}, 8'h01);
        check("R10 master vector input 2", m_vec, 8'h42);
        check("R5 slave vector input 5", s_vec, 8'h4D);
        bus_wr(0, 0, 8'h0A);
        bus_rd(0, 0, v); check("R10 master request bit 2", v, 8'h04);
        bus_wr(0, 0, 8'h0C);
        bus_rd(0, 0, v); check("R6 master poll input 2", v, 8'h82);
        bus_wr(1, 0, 8'h0C);
        bus_rd(1, 0, v); check("R6 slave poll input 5", v, 8'hA5 & 8'h85);
        s_irq = 8'h00;
        bus_wr(1, 0, 8'h0B);
        bus_rd(1, 0, v); check("R6 slave in-service", v, 8'h20);
        bus_wr(1, 0, 8'h65);
        bus_wr(0, 0, 8'h0B);
        bus_rd(0, 0, v); check("R6 master in-service", v, 8'h04);
        bus_wr(0, 0, 8'h62);
        bus_rd(0, 0, v); check("R8 master EOI of chain input", v, 8'h00);
        bus_rd(1, 0, v); check("R8 slave EOI", v, 8'h00);
    endtask

    task automatic t_reinit();
        logic [7:0] v;
        m_irq = 8'h01;
        wait_cyc(1);
        bus_wr(0, 0, 8'h0C);
        bus_rd(0, 0, v); check("R6 poll input 0", v, 8'h80);
        bus_wr(0, 1, 8'h55);
        bus_wr(0, 0, 8'h11);
        check("R3 int_out held on restart", {7'b0, m_int}, 8'h00);
        bus_rd(0, 1, v); check("R2 restart clears mask", v, 8'h00);
        bus_rd(0, 0, v); check("R2 restart selects request register", v, 8'h01);
        bus_wr(0, 1, 8'h40);
        bus_wr(0, 1, 8'h04);
        bus_wr(0, 1, 8'h01);
        bus_wr(0, 0, 8'h0B);
        bus_rd(0, 0, v); check("R2 restart cleared in-service", v, 8'h00);
        check("R3 int_out after restart", {7'b0, m_int}, 8'h01);
        m_irq = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_init();
        t_mask();
        t_irr();
        t_poll();
        t_preempt();
        t_eoi();
        t_spurious();
        t_cascade();
        t_reinit();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule